// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit ports, A and B. Data can cross in either direction in real time through a purely combinational path. Data can also be captured into one of two edge-triggered holding registers and sent out later. Each direction has its own holding register and its own capture clock. A per-direction select line chooses whether the receiving port shows the live value from the far port or the stored word.

An active-low output enable and a direction line decide which port, if any, is driven. At most one port is driven at a time. Each port has a separate data input, data output and drive-enable output, so no tristate nets are needed inside the chip. Capture never depends on the enable or direction lines. A word stored while both ports are quiet, or from the port that is currently receiving, can be put on the bus later.

Top module: `xfer_reg_xcvr`

## Requirements
- R1: On each rising edge of `clk_ab` with `rst_n` high, the A-to-B register loads `a_in`. On each rising edge of `clk_ba` with `rst_n` high, the B-to-A register loads `b_in`.
- R2: A rising edge of either capture clock while `rst_n` is low clears that direction's register to zero.
- R3: With `oe_n` = 0 and `dir_atob` = 1, `b_drv` is 1 and `a_drv` is 0.
- R4: With `oe_n` = 0 and `dir_atob` = 0, `a_drv` is 1 and `b_drv` is 0.
- R5: With `oe_n` = 1, both `a_drv` and `b_drv` are 0 whatever the other controls are.
- R6: `a_drv` and `b_drv` are never 1 at the same time.
- R7: `b_out` equals `a_in` in the same cycle, with no clock, when `sel_ab` = 0. It equals the A-to-B register when `sel_ab` = 1.
- R8: `a_out` equals `b_in` in the same cycle when `sel_ba` = 0. It equals the B-to-A register when `sel_ba` = 1.
- R9: Captures happen for every setting of `oe_n` and `dir_atob`. A word captured in isolation mode appears on the output once that port is enabled with its select at 1.
- R10: A register keeps its content across edges of the other direction's clock and across any change of the data inputs without its own clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| rst_n | input | 1 | Synchronous active-low clear, sampled by each capture clock |
| oe_n | input | 1 | Active-low output enable for both ports |
| dir_atob | input | 1 | 1: port B driven from the A side; 0: port A driven from the B side |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| a_in | input | 8 | Data arriving on port A |
| a_out | output | 8 | Data offered to port A |
| a_drv | output | 1 | Port A drive enable |
| b_in | input | 8 | Data arriving on port B |
| b_out | output | 8 | Data offered to port B |
| b_drv | output | 1 | Port B drive enable |

## Verification
Some properties are checked continuously by assertions. These are the exclusion of the two drive enables, the silence of both ports in isolation mode, the choice of the driven port from the direction line, and the loading of each register from its own port on its own clock edge. Other behaviour shows only in the bench's scenarios. This covers words captured in isolation and released later, a register holding its value while the other clock toggles, the live path following its input in the same cycle, and a nonzero register being cleared by reset.

// File: rtl/xfer_reg_xcvr.sv
module xfer_reg_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             rst_n,
  input  logic             oe_n,
  input  logic             dir_atob,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv
);

  logic [WIDTH-1:0] stored_ab;
  logic [WIDTH-1:0] stored_ba;

  always_ff @(posedge clk_ab) begin
    if (!rst_n) stored_ab <= '0;
    else        stored_ab <= a_in;
  end

  always_ff @(posedge clk_ba) begin
    if (!rst_n) stored_ba <= '0;
    else        stored_ba <= b_in;
  end

  assign b_out = sel_ab ? stored_ab : a_in;
  assign a_out = sel_ba ? stored_ba : b_in;

  assign b_drv = ~oe_n &  dir_atob;
  assign a_drv = ~oe_n & ~dir_atob;

  always_comb begin
    assert_drv_exclusive_R6: assert (!(a_drv && b_drv));
    if (oe_n === 1'b1)
      assert_isolation_quiet_R5: assert (!a_drv && !b_drv);
    if (oe_n === 1'b0 && dir_atob === 1'b1)
      assert_dir_selects_b_R3: assert (b_drv && !a_drv);
    if (oe_n === 1'b0 && dir_atob === 1'b0)
      assert_dir_selects_a_R4: assert (a_drv && !b_drv);
  end

  assert_capture_ab_R1: assert property (@(posedge clk_ab) disable iff (!rst_n)
    rst_n |=> stored_ab == $past(a_in));

  assert_capture_ba_R1: assert property (@(posedge clk_ba) disable iff (!rst_n)
    rst_n |=> stored_ba == $past(b_in));

endmodule

// File: tb/xfer_reg_xcvr_tb.sv
module xfer_reg_xcvr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk_ab = 0, clk_ba = 0, rst_n = 0;
  logic oe_n = 1, dir_atob = 0, sel_ab = 0, sel_ba = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drv, b_drv;

  xfer_reg_xcvr #(.WIDTH(W)) u_dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n), .oe_n(oe_n),
    .dir_atob(dir_atob), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv)
  );

  typedef struct {
    logic [2*W+1:0] exp;
    string          tag;
  } item_t;

  item_t q[$];
  event sample_ev;
  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [2*W+1:0] act;
        it = q.pop_front();
        act = {a_out, a_drv, b_out, b_drv};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
        n_cmp++;
        if (a_drv && b_drv) begin
          n_bad++;
          $display("FAIL R6 actual a_drv=1 b_drv=1 expected at most one");
        end
      end
    end
  end

  task automatic expect_now(input string tag);
    item_t it;
    logic ad, bd;
    ad = !oe_n && !dir_atob;
    bd = !oe_n && dir_atob;
    it.exp = {(sel_ba ? m_ba : b_in), ad, (sel_ab ? m_ab : a_in), bd};
    it.tag = tag;
    #1;
    q.push_back(it);
    ->sample_ev;
    #1;
  endtask

  task automatic pulse_ab();
    #(CLK_PERIOD/2) clk_ab = 1;
    m_ab = rst_n ? a_in : '0;
    #(CLK_PERIOD/2) clk_ab = 0;
  endtask

  task automatic pulse_ba();
    #(CLK_PERIOD/2) clk_ba = 1;
    m_ba = rst_n ? b_in : '0;
    #(CLK_PERIOD/2) clk_ba = 0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    a_in = 8'hA7; b_in = 8'h3C;
    pulse_ab(); pulse_ba();
    rst_n = 1;
    sel_ab = 1; sel_ba = 1; oe_n = 0; dir_atob = 1;
    expect_now("R2 reset state");

    for (int i = 0; i < 16; i++) begin
      oe_n = i[0]; dir_atob = i[1]; sel_ab = i[2]; sel_ba = i[3];
      a_in = 8'h11 * i[7:0] + 8'h05; b_in = ~a_in;
      expect_now(oe_n ? "R5 R7 R8 isolation" : (dir_atob ? "R3 R7 R8 a-to-b" : "R4 R7 R8 b-to-a"));
      a_in = a_in ^ 8'hFF;
      expect_now("R7 R8 live follows input");
    end

    oe_n = 1; sel_ab = 1; sel_ba = 1;
    a_in = 8'h5A; pulse_ab();
    b_in = 8'hC3; pulse_ba();
    a_in = 8'h00; b_in = 8'hFF;
    expect_now("R9 isolation capture held");
    oe_n = 0; dir_atob = 1;
    expect_now("R9 stored A word on B");
    dir_atob = 0;
    expect_now("R9 stored B word on A");

    a_in = 8'h81; pulse_ab();
    b_in = 8'h42; a_in = 8'h99;
    expect_now("R10 B-to-A register unchanged by clk_ab");
    b_in = 8'h24; pulse_ba();
    a_in = 8'h77; b_in = 8'h66;
    expect_now("R10 A-to-B register unchanged by clk_ba");

    oe_n = 0; dir_atob = 1;
    a_in = 8'hE1; b_in = 8'h1E;
    pulse_ab(); pulse_ba();
    expect_now("R1 capture while transceiving");
    sel_ab = 0;
    expect_now("R7 live path selected");
    sel_ab = 1;

    rst_n = 0; pulse_ab();
    rst_n = 1;
    expect_now("R2 clear A-to-B only");
    rst_n = 0; pulse_ba();
    rst_n = 1;
    expect_now("R2 clear B-to-A");

    #(CLK_PERIOD);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule